// File: doc/BRIEF.md
# Leading-One Segment Approximate Multiplier

This combinational block forms an approximate product of two signed 8-bit operands. For each operand it locates the highest set bit and keeps a 4-bit window. The window is that bit plus the three bits just below it. It also records the window's distance from bit zero. The two windows are multiplied, and the product is scaled back by shifting it left by the sum of both distances. This replaces a full 8x8 array with a 4x4 multiply, a small priority encoder and a barrel shifter.

The two operand sign bits select how the windows are multiplied. If the signs match, both windows are multiplied as unsigned numbers. If they differ, the window of the non-negative operand gets a zero bit on top, and the window of the negative operand is read as a signed 4-bit value. Every multiply and shift is done at the full 16-bit result width, so the sign is never lost.

Top module: `dsm_mult`

## Requirements
- R1: If either operand is zero, the result is 0.
- R2: An operand whose highest set bit is at index 3 or below, or which is zero, uses its low 4 bits as its window with distance 0. So for two operands in 0..15 the result is their exact product.
- R3: Otherwise, when the highest set bit is at index p (4..7), the window is operand bits [p:p-3] and its distance is p-3. Example: 0x5B times 1 gives 11 shifted left by 3 = 88.
- R4: The window product is shifted left by the sum of both distances. Every result bit below that sum is zero. Example: 0x30 times 0x40 gives 96 shifted left by 5 = 3072.
- R5: When the sign bits {a[7], b[7]} are 00 or 11, the windows are multiplied as unsigned numbers. Example: 0xFF times 0xFF gives 225 shifted left by 8 = 0xE100.
- R6: When the sign bits {a[7], b[7]} are 01, the a-window is zero-extended and the b-window is read as signed 4-bit. Example: 0x01 times 0x80 gives 0xFF80, and 0x7F times 0xFF gives 0xF880.
- R7: When the sign bits {a[7], b[7]} are 10, the a-window is read as signed 4-bit and the b-window is zero-extended. Example: 0x80 times 0x01 gives 0xFF80. With opposite signs and both operands non-zero, result bit 15 is 1.
- R8: The result is a 16-bit two's complement value, and swapping the operands does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand, two's complement |
| b_i | input | 8 | Second operand, two's complement |
| prod_o | output | 16 | Approximate product, two's complement |

## Verification
Every one of the 65,536 operand pairs is driven and compared against a behavioural integer model of the windowing rule. This covers all four sign-bit combinations and every position of the leading one.

Directed pairs separate the individual behaviours:
- Zero and small operands show the exact low-window path.
- Operands with the leading one at different heights show window placement and the shift sum.
- Pairs that are all ones and the most negative value expose the sign-extension choice in each sign case.
- Swapped pairs confirm the two mixed-sign cases mirror each other.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int unsigned OP_W  = 8;
  localparam int unsigned SEG_W = 4;

  typedef enum logic [1:0] {
    SGN_PP = 2'b00,
    SGN_PN = 2'b01,
    SGN_NP = 2'b10,
    SGN_NN = 2'b11
  } sign_pair_e;
endpackage

// File: rtl/dsm_lod.sv
// Leading-one window extraction for one operand
module dsm_lod #(
  parameter int unsigned OP_W    = 8,
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned SHIFT_W = $clog2(OP_W - SEG_W + 1)
) (
  input  logic [OP_W-1:0]    op_i,
  output logic [SEG_W-1:0]   seg_o,
  output logic [SHIFT_W-1:0] shift_o
);
  localparam int unsigned NUM_POS = OP_W - SEG_W + 1;

  logic [SEG_W-1:0] win [NUM_POS];

  for (genvar k = 0; k < NUM_POS; k++) begin : g_win
    assign win[k] = op_i[k+SEG_W-1:k];
  end

  // highest set bit above the low window wins
  always_comb begin
    shift_o = '0;
    for (int i = SEG_W; i < OP_W; i++) begin
      if (op_i[i]) shift_o = SHIFT_W'(i - SEG_W + 1);
    end
  end

  always_comb begin
    seg_o = '0;
    for (int k = 0; k < NUM_POS; k++) begin
      if (shift_o == SHIFT_W'(k)) seg_o = win[k];
    end
  end
endmodule

// File: rtl/dsm_seg_mul.sv
// Sign-pair controlled segment multiply at full result width
module dsm_seg_mul
  import dsm_pkg::*;
#(
  parameter int unsigned SEG_W = 4,
  parameter int unsigned RES_W = 16
) (
  input  logic [SEG_W-1:0] seg_a_i,
  input  logic [SEG_W-1:0] seg_b_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  output logic [RES_W-1:0] mul_o
);
  localparam int unsigned EXT_W = RES_W - SEG_W;

  logic [RES_W-1:0] a_zx, b_zx, a_sx, b_sx;
  sign_pair_e       sel;

  assign a_zx = {{EXT_W{1'b0}}, seg_a_i};
  assign b_zx = {{EXT_W{1'b0}}, seg_b_i};
  assign a_sx = {{EXT_W{seg_a_i[SEG_W-1]}}, seg_a_i};
  assign b_sx = {{EXT_W{seg_b_i[SEG_W-1]}}, seg_b_i};
  assign sel  = sign_pair_e'({sign_a_i, sign_b_i});

  // two's complement product modulo 2^RES_W once both sides are extended
  always_comb begin
    case (sel)
      SGN_PN:  mul_o = a_zx * b_sx;
      SGN_NP:  mul_o = a_sx * b_zx;
      default: mul_o = a_zx * b_zx;
    endcase
  end
endmodule

// File: rtl/dsm_mult.sv
module dsm_mult
  import dsm_pkg::*;
#(
  parameter int unsigned OP_W  = dsm_pkg::OP_W,
  parameter int unsigned SEG_W = dsm_pkg::SEG_W
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int unsigned RES_W   = 2 * OP_W;
  localparam int unsigned SHIFT_W = $clog2(OP_W - SEG_W + 1);
  localparam int unsigned SUM_W   = $clog2(2 * (OP_W - SEG_W) + 1);

  logic [SEG_W-1:0]   seg_a, seg_b;
  logic [SHIFT_W-1:0] shift_a, shift_b;
  logic [SUM_W-1:0]   shift_sum;
  logic [RES_W-1:0]   mul;

  dsm_lod #(.OP_W(OP_W), .SEG_W(SEG_W), .SHIFT_W(SHIFT_W)) u_lod_a (
    .op_i(a_i), .seg_o(seg_a), .shift_o(shift_a)
  );

  dsm_lod #(.OP_W(OP_W), .SEG_W(SEG_W), .SHIFT_W(SHIFT_W)) u_lod_b (
    .op_i(b_i), .seg_o(seg_b), .shift_o(shift_b)
  );

  dsm_seg_mul #(.SEG_W(SEG_W), .RES_W(RES_W)) u_mul (
    .seg_a_i (seg_a),
    .seg_b_i (seg_b),
    .sign_a_i(a_i[OP_W-1]),
    .sign_b_i(b_i[OP_W-1]),
    .mul_o   (mul)
  );

  assign shift_sum = SUM_W'(shift_a) + SUM_W'(shift_b);
  assign prod_o    = mul << shift_sum;
endmodule

// File: rtl/dsm_mult_chk.sv
module dsm_mult_chk #(
  parameter int unsigned OP_W    = 8,
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned SUM_W   = 4
) (
  input logic [OP_W-1:0]    a_i,
  input logic [OP_W-1:0]    b_i,
  input logic [2*OP_W-1:0]  prod_o,
  input logic [SEG_W-1:0]   seg_a,
  input logic [SHIFT_W-1:0] shift_a,
  input logic [SUM_W-1:0]   shift_sum
);
  localparam int unsigned RES_W = 2 * OP_W;

  logic [RES_W-1:0] low_mask;
  assign low_mask = ~({RES_W{1'b1}} << shift_sum);

  always_comb begin
    a_r1_zero_operand: assert (!(a_i == '0 || b_i == '0) || prod_o == '0);
    a_r2_small_exact: assert (!(a_i[OP_W-1:SEG_W] == '0 && b_i[OP_W-1:SEG_W] == '0)
                              || prod_o == RES_W'(a_i) * RES_W'(b_i));
    a_r3_window_top_set: assert (shift_a == '0 || seg_a[SEG_W-1]);
    a_r4_low_bits_clear: assert ((prod_o & low_mask) == '0);
    a_r7_mixed_sign_negative: assert (!((a_i[OP_W-1] ^ b_i[OP_W-1]) && a_i != '0 && b_i != '0)
                                      || prod_o[RES_W-1]);
  end
endmodule

bind dsm_mult dsm_mult_chk #(
  .OP_W(OP_W), .SEG_W(SEG_W), .SHIFT_W(SHIFT_W), .SUM_W(SUM_W)
) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .prod_o   (prod_o),
  .seg_a    (seg_a),
  .shift_a  (shift_a),
  .shift_sum(shift_sum)
);

// File: tb/dsm_mult_tb.sv
`timescale 1ns/1ps
module dsm_mult_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a, b;
  logic [15:0] prod;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  dsm_mult u_dut (.a_i(a), .b_i(b), .prod_o(prod));

  function automatic void window(input logic [7:0] x, output int seg, output int sh);
    int p = -1;
    for (int i = 7; i >= 0; i--) if (x[i] && p < 0) p = i;
    if (p <= 3) begin
      seg = int'(x) & 15; sh = 0;
    end else begin
      sh = p - 3; seg = (int'(x) >> sh) & 15;
    end
  endfunction

  function automatic logic [15:0] model(input logic [7:0] x, input logic [7:0] y);
    int sx, sy, hx, hy, vx, vy, r;
    window(x, sx, hx);
    window(y, sy, hy);
    vx = sx; vy = sy;
    if (x[7] && !y[7] && sx >= 8) vx = sx - 16;
    if (!x[7] && y[7] && sy >= 8) vy = sy - 16;
    r = vx * vy * (1 << (hx + hy));
    return 16'(r & 32'hFFFF);
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_cmp++;
    if (prod !== exp) begin
      n_bad++;
      $display("FAIL %s a=%02h b=%02h got=%04h exp=%04h", req, a, b, prod, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y);
    @(posedge clk_i);
    a = x; b = y;
    @(negedge clk_i);
  endtask

  task automatic directed(input string req, input logic [7:0] x, input logic [7:0] y,
                          input logic [15:0] exp);
    apply(x, y);
    check(req, exp);
  endtask

  initial begin
    logic [15:0] first;
    a = '0; b = '0;
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset", 16'h0000);

    directed("R1", 8'h00, 8'h7F, 16'h0000);
    directed("R1", 8'h93, 8'h00, 16'h0000);
    directed("R2", 8'd13, 8'd11, 16'd143);
    directed("R2", 8'd15, 8'd15, 16'd225);
    directed("R3", 8'h5B, 8'h01, 16'd88);
    directed("R4", 8'h30, 8'h40, 16'd3072);
    directed("R5", 8'hFF, 8'hFF, 16'hE100);
    directed("R5", 8'h7F, 8'h7F, 16'h3840);
    directed("R6", 8'h01, 8'h80, 16'hFF80);
    directed("R6", 8'h7F, 8'hFF, 16'hF880);
    directed("R7", 8'h80, 8'h01, 16'hFF80);
    directed("R7", 8'hFF, 8'h7F, 16'hF880);

    apply(8'h23, 8'h9C);
    first = prod;
    check("R8 model", model(8'h23, 8'h9C));
    apply(8'h9C, 8'h23);
    check("R8 swap", first);

    // exhaustive sweep covers R3..R7 windowing and sign cases
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(8'(i), 8'(j));
        check("R3-sweep", model(8'(i), 8'(j)));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule